// File: doc/BRIEF.md
# Serial DRAM Sample Recorder and Looping Player

This block turns a plain one-bit-wide asynchronous DRAM into a long bit recorder. After reset it captures one bit from a serial input on every sample tick and stores it at the next location of the DRAM. When every location holds a bit, it changes for good to playback. From then on each tick reads the next stored bit back to the serial output, and the address wraps around so the recording repeats without end.

Every step, whether a record or a play step, starts with a short burst of refresh cycles in which CAS falls before RAS. The DRAM's own internal row counter picks the rows, so a burst per tick keeps the array alive as long as ticks come often enough. The sample address is split into a row field and a column field. Both go out on one shared multiplexed address bus, the row first and then the column. The row field counts first and carries into the column field. Each strobe phase lasts a set number of clock cycles, so the DRAM's RAS, CAS, precharge and row-to-column timing can be met at any clock rate.

Top module: `drp_top`

## Requirements
- R1: While reset is held, RAS, CAS and WE stay high, the data line is not driven, `ctlOe` is low and the mode is record. `ctlOe` goes high one cycle after reset is released.
- R2: Access number n (counted from 0 since reset) uses row = n mod 2^ADDR_W and column = n div 2^ADDR_W, both taken modulo 2^(2*ADDR_W). The row is on the bus when RAS falls and the column is on the bus when CAS falls. The address holds steady while RAS and CAS are both low.
- R3: In a write, WE falls while RAS is low and before CAS falls. WE then rises before RAS, and RAS rises before CAS. WE never goes low while RAS is high.
- R4: In a record step, the bit on `sinBit` is written to the DRAM and appears on `sOut` by the end of that step. The data line holds steady while it is driven.
- R5: Each access comes after exactly REFRESH_CNT refresh cycles in which CAS falls before RAS.
- R6: `playMode` goes high when the write to the last location (row and column both all-ones) ends, and it then stays high until reset.
- R7: In playback, step k reads location k mod 2^(2*ADDR_W) and drives the stored bit onto `sOut`. The address wraps from the last location back to row 0, column 0.
- R8: `dramDOe` is high only during write accesses. It is never high in playback, and no write takes place in playback.
- R9: Steps run only on a tick. With no tick, no DRAM access occurs.
- R10: A tick that arrives while a step is running is held, and it starts one more step when the current step ends.
- R11: In an access, the time from RAS falling to CAS falling is RAS_CYC + SETUP_CYC clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleTick | input | 1 | One-cycle pulse that requests one step |
| sinBit | input | 1 | Serial input bit to record |
| dramQ | input | 1 | DRAM data output |
| ctlOe | output | 1 | Enable for the address and control outputs, high from one cycle after reset |
| dramAddr | output | ADDR_W | Multiplexed row/column address |
| dramRasN | output | 1 | Row strobe, active low |
| dramCasN | output | 1 | Column strobe, active low |
| dramWeN | output | 1 | Write enable, active low |
| dramD | output | 1 | DRAM data input line |
| dramDOe | output | 1 | Drive enable for dramD |
| sOut | output | 1 | Serial output (echo in record, stored bit in playback) |
| playMode | output | 1 | 0 = record, 1 = playback |

## Verification
The hardest state to reach is the switch from record to playback, followed by the first wrap back to address zero. At the default width this needs about a million steps. The bench therefore shrinks ADDR_W to 2, which gives 16 locations. It records a table of 16 bits and then plays two full passes, which crosses the wrap. A behavioural DRAM in the bench stores the data and checks the strobe order and the refresh count. A tick placed in the middle of a running step exercises the pending path, and a reset asserted during a refresh burst tests the abort.

// File: rtl/drp_pkg.sv
package drp_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RF_CAS,
    ST_RF_BOTH,
    ST_RF_RAS,
    ST_RF_PRE,
    ST_AC_ROW,
    ST_AC_RAS,
    ST_AC_COL,
    ST_AC_CAS,
    ST_AC_WEREL,
    ST_AC_RASREL,
    ST_AC_PRE
  } drp_state_e;

  typedef struct packed {
    logic rasN;
    logic casN;
    logic weN;
    logic selCol;
    logic driveD;
    logic latchIn;
    logic capQ;
    logic incAddr;
  } drp_stb_t;

endpackage

// File: rtl/drp_ctrl.sv
module drp_ctrl
  import drp_pkg::*;
#(
  parameter int REFRESH_CNT = 8,
  parameter int SETUP_CYC   = 1,
  parameter int RAS_CYC     = 2,
  parameter int CAS_CYC     = 2,
  parameter int PRE_CYC     = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     sampleTick,
  input  logic     playMode,
  output drp_stb_t stb
);

  localparam int MAX_A = (SETUP_CYC > RAS_CYC) ? SETUP_CYC : RAS_CYC;
  localparam int MAX_B = (CAS_CYC > PRE_CYC) ? CAS_CYC : PRE_CYC;
  localparam int MAX_D = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int TW    = $clog2(MAX_D + 1);
  localparam int RW    = $clog2(REFRESH_CNT + 1);

  drp_state_e state, nextState;
  logic [TW-1:0] timer;
  logic [RW-1:0] refCnt;
  logic pend, isWr, advance;

  function automatic logic [TW-1:0] phaseLen(drp_state_e s);
    case (s)
      ST_RF_CAS, ST_AC_ROW, ST_AC_COL: phaseLen = TW'(SETUP_CYC - 1);
      ST_RF_BOTH, ST_AC_RAS:           phaseLen = TW'(RAS_CYC - 1);
      ST_RF_RAS, ST_AC_CAS:            phaseLen = TW'(CAS_CYC - 1);
      ST_RF_PRE, ST_AC_PRE:            phaseLen = TW'(PRE_CYC - 1);
      default:                         phaseLen = '0;
    endcase
  endfunction

  assign advance = (state == ST_IDLE) ? pend : (timer == '0);

  always_comb begin
    nextState = state;
    case (state)
      ST_IDLE:      nextState = ST_RF_CAS;
      ST_RF_CAS:    nextState = ST_RF_BOTH;
      ST_RF_BOTH:   nextState = ST_RF_RAS;
      ST_RF_RAS:    nextState = ST_RF_PRE;
      ST_RF_PRE:    nextState = (refCnt == RW'(REFRESH_CNT - 1)) ? ST_AC_ROW : ST_RF_CAS;
      ST_AC_ROW:    nextState = ST_AC_RAS;
      ST_AC_RAS:    nextState = ST_AC_COL;
      ST_AC_COL:    nextState = ST_AC_CAS;
      ST_AC_CAS:    nextState = isWr ? ST_AC_WEREL : ST_AC_RASREL;
      ST_AC_WEREL:  nextState = ST_AC_RASREL;
      ST_AC_RASREL: nextState = ST_AC_PRE;
      ST_AC_PRE:    nextState = ST_IDLE;
      default:      nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      timer  <= '0;
      refCnt <= '0;
      pend   <= 1'b0;
      isWr   <= 1'b0;
    end else begin
      pend <= (pend && !(state == ST_IDLE)) || sampleTick;
      if (advance) begin
        state <= nextState;
        timer <= phaseLen(nextState);
        if (state == ST_IDLE) begin
          isWr   <= !playMode;
          refCnt <= '0;
        end else if (state == ST_RF_PRE) begin
          refCnt <= refCnt + 1'b1;
        end
      end else begin
        timer <= timer - 1'b1;
      end
    end
  end

  always_comb begin
    stb = '{rasN: 1'b1, casN: 1'b1, weN: 1'b1, selCol: 1'b0,
            driveD: 1'b0, latchIn: 1'b0, capQ: 1'b0, incAddr: 1'b0};
    case (state)
      ST_RF_CAS:  stb.casN = 1'b0;
      ST_RF_BOTH: begin stb.casN = 1'b0; stb.rasN = 1'b0; end
      ST_RF_RAS:  stb.rasN = 1'b0;
      ST_AC_ROW:  stb.latchIn = advance && isWr;
      ST_AC_RAS:  begin stb.rasN = 1'b0; stb.driveD = isWr; end
      ST_AC_COL: begin
        stb.rasN = 1'b0; stb.selCol = 1'b1;
        stb.driveD = isWr; stb.weN = !isWr;
      end
      ST_AC_CAS: begin
        stb.rasN = 1'b0; stb.casN = 1'b0; stb.selCol = 1'b1;
        stb.driveD = isWr; stb.weN = !isWr;
        stb.capQ = advance && !isWr;
      end
      ST_AC_WEREL: begin
        stb.rasN = 1'b0; stb.casN = 1'b0; stb.selCol = 1'b1; stb.driveD = 1'b1;
      end
      ST_AC_RASREL: begin
        stb.casN = 1'b0; stb.selCol = 1'b1; stb.incAddr = advance;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/drp_datapath.sv
module drp_datapath
  import drp_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  drp_stb_t          stb,
  input  logic              sinBit,
  input  logic              dramQ,
  output logic              ctlOe,
  output logic [ADDR_W-1:0] dramAddr,
  output logic              dramD,
  output logic              sOut,
  output logic              playMode
);

  localparam logic [ADDR_W-1:0] FIELD_MAX = '1;

  logic [ADDR_W-1:0] rowCtr, colCtr;
  logic sampleBit;

  assign dramAddr = stb.selCol ? colCtr : rowCtr;
  assign dramD    = sampleBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowCtr    <= '0;
      colCtr    <= '0;
      playMode  <= 1'b0;
      sOut      <= 1'b0;
      sampleBit <= 1'b0;
      ctlOe     <= 1'b0;
    end else begin
      ctlOe <= 1'b1;
      if (stb.latchIn) begin
        sampleBit <= sinBit;
        sOut      <= sinBit;
      end
      if (stb.capQ) sOut <= dramQ;
      if (stb.incAddr) begin
        if (rowCtr == FIELD_MAX) begin
          rowCtr <= '0;
          if (colCtr == FIELD_MAX) begin
            colCtr   <= '0;
            playMode <= 1'b1;
          end else begin
            colCtr <= colCtr + 1'b1;
          end
        end else begin
          rowCtr <= rowCtr + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/drp_top.sv
module drp_top
  import drp_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int REFRESH_CNT = 8,
  parameter int SETUP_CYC   = 1,
  parameter int RAS_CYC     = 2,
  parameter int CAS_CYC     = 2,
  parameter int PRE_CYC     = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleTick,
  input  logic              sinBit,
  input  logic              dramQ,
  output logic              ctlOe,
  output logic [ADDR_W-1:0] dramAddr,
  output logic              dramRasN,
  output logic              dramCasN,
  output logic              dramWeN,
  output logic              dramD,
  output logic              dramDOe,
  output logic              sOut,
  output logic              playMode
);

  drp_stb_t stb;

  drp_ctrl #(
    .REFRESH_CNT(REFRESH_CNT), .SETUP_CYC(SETUP_CYC), .RAS_CYC(RAS_CYC),
    .CAS_CYC(CAS_CYC), .PRE_CYC(PRE_CYC)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .playMode(playMode), .stb(stb)
  );

  drp_datapath #(.ADDR_W(ADDR_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .sinBit(sinBit), .dramQ(dramQ),
    .ctlOe(ctlOe), .dramAddr(dramAddr), .dramD(dramD), .sOut(sOut),
    .playMode(playMode)
  );

  assign dramRasN = stb.rasN;
  assign dramCasN = stb.casN;
  assign dramWeN  = stb.weN;
  assign dramDOe  = stb.driveD;

endmodule

// File: rtl/drp_checker.sv
module drp_checker #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              ctlOe,
  input logic [ADDR_W-1:0] dramAddr,
  input logic              dramRasN,
  input logic              dramCasN,
  input logic              dramWeN,
  input logic              dramD,
  input logic              dramDOe,
  input logic              playMode
);

  p_idle_strobes_r1: assert property (@(posedge clk)
    !rstN |-> (dramRasN && dramCasN && dramWeN && !dramDOe && !ctlOe && !playMode));

  p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!dramRasN && !dramCasN && $past(!dramRasN) && $past(!dramCasN)) |-> $stable(dramAddr));

  p_we_inside_ras_r3: assert property (@(posedge clk) disable iff (!rstN)
    !dramWeN |-> !dramRasN);

  p_we_before_cas_r3: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(dramCasN) && !dramRasN && dramDOe) |-> !dramWeN);

  p_wdata_stable_r4: assert property (@(posedge clk) disable iff (!rstN)
    (dramDOe && $past(dramDOe)) |-> $stable(dramD));

  p_mode_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    $past(playMode) |-> playMode);

  p_no_drive_in_play_r8: assert property (@(posedge clk) disable iff (!rstN)
    playMode |-> (!dramDOe && dramWeN));

endmodule

bind drp_top drp_checker #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rstN(rstN), .ctlOe(ctlOe), .dramAddr(dramAddr),
  .dramRasN(dramRasN), .dramCasN(dramCasN), .dramWeN(dramWeN),
  .dramD(dramD), .dramDOe(dramDOe), .playMode(playMode)
);

// File: tb/drp_top_tb_top.sv
`timescale 1ns/1ps
module drp_top_tb_top;

  localparam int AW     = 2;
  localparam int NLOC   = 16;
  localparam int NREF   = 3;
  localparam int SETUPC = 1;
  localparam int RASC   = 2;
  localparam int STEP_WAIT = 50;

  // each entry: {bit to record, expected column, expected row}
  localparam logic [4:0] VEC [0:NLOC-1] = '{
    5'b1_00_00, 5'b0_00_01, 5'b1_00_10, 5'b1_00_11,
    5'b0_01_00, 5'b0_01_01, 5'b1_01_10, 5'b0_01_11,
    5'b1_10_00, 5'b1_10_01, 5'b1_10_10, 5'b0_10_11,
    5'b0_11_00, 5'b1_11_01, 5'b0_11_10, 5'b1_11_11
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleTick = 1'b0;
  logic sinBit = 1'b0;
  logic dramQ;
  logic ctlOe, dramRasN, dramCasN, dramWeN, dramD, dramDOe, sOut, playMode;
  logic [AW-1:0] dramAddr;

  always #2.5 clk = ~clk;

  drp_top #(.ADDR_W(AW), .REFRESH_CNT(NREF), .SETUP_CYC(SETUPC), .RAS_CYC(RASC),
            .CAS_CYC(2), .PRE_CYC(1)) dut_i (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .sinBit(sinBit), .dramQ(dramQ),
    .ctlOe(ctlOe), .dramAddr(dramAddr), .dramRasN(dramRasN), .dramCasN(dramCasN),
    .dramWeN(dramWeN), .dramD(dramD), .dramDOe(dramDOe), .sOut(sOut),
    .playMode(playMode)
  );

  // behavioural DRAM, sampled on the falling clock edge
  logic mem [0:NLOC-1];
  logic [AW-1:0] rowL = '0, colL = '0;
  logic prevRas = 1'b1, prevCas = 1'b1, inAccess = 1'b0;
  int cyc = 0, rasFallCyc = 0, refCount = 0, lastRef = 0, lastRcd = 0;
  int accesses = 0, orderErr = 0, doeInPlay = 0;
  logic lastWasWrite = 1'b0, lastData = 1'b0;
  logic [AW-1:0] lastRow = '0, lastCol = '0;

  assign dramQ = mem[{colL, rowL}];

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (!rstN) begin
      refCount <= 0;
      inAccess <= 1'b0;
    end else begin
      if (prevRas && !dramRasN) begin
        if (!dramCasN) refCount <= refCount + 1;
        else begin rowL <= dramAddr; rasFallCyc <= cyc; inAccess <= 1'b1; end
      end
      if (prevCas && !dramCasN && !dramRasN && inAccess) begin
        colL     <= dramAddr;
        accesses <= accesses + 1;
        lastRcd  <= cyc - rasFallCyc;
        lastRef  <= refCount;
        refCount <= 0;
        lastRow  <= rowL;
        lastCol  <= dramAddr;
        lastWasWrite <= !dramWeN;
        if (!dramWeN) begin
          mem[{dramAddr, rowL}] <= dramD;
          lastData <= dramD;
          if (!dramDOe) orderErr <= orderErr + 1;
        end
      end
      if (!prevRas && dramRasN && inAccess && !dramWeN) orderErr <= orderErr + 1;
      if (!prevCas && dramCasN && inAccess) begin
        if (!dramRasN) orderErr <= orderErr + 1;
        inAccess <= 1'b0;
      end
      if (playMode && dramDOe) doeInPlay <= doeInPlay + 1;
    end
    prevRas <= dramRasN;
    prevCas <= dramCasN;
  end

  int compared = 0, mismatched = 0;
  logic done = 1'b0;

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulseTick();
    @(negedge clk) sampleTick = 1'b1;
    @(negedge clk) sampleTick = 1'b0;
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    for (int k = 0; k < NLOC; k++) mem[k] = 1'b0;
  end

  initial begin
    int acc0;
    waitCyc(3);
    // R1: reset state
    check("R1 rasN in reset", int'(dramRasN), 1);
    check("R1 casN in reset", int'(dramCasN), 1);
    check("R1 weN in reset", int'(dramWeN), 1);
    check("R1 ctlOe in reset", int'(ctlOe), 0);
    check("R1 doe in reset", int'(dramDOe), 0);
    rstN = 1'b1;
    waitCyc(2);
    check("R1 ctlOe after release", int'(ctlOe), 1);
    check("R6 mode after reset", int'(playMode), 0);

    // record: walk the vector table
    for (int i = 0; i < NLOC; i++) begin
      sinBit = VEC[i][4];
      pulseTick();
      waitCyc(STEP_WAIT);
      check("R2 write row", int'(lastRow), int'(VEC[i][1:0]));
      check("R2 write col", int'(lastCol), int'(VEC[i][3:2]));
      check("R4 stored bit", int'(lastData), int'(VEC[i][4]));
      check("R4 echo on sOut", int'(sOut), int'(VEC[i][4]));
      check("R3 write cycle", int'(lastWasWrite), 1);
      check("R5 refresh count", lastRef, NREF);
      check("R11 ras to cas", lastRcd, RASC + SETUPC);
      check("R6 mode", int'(playMode), (i == NLOC - 1) ? 1 : 0);
    end
    check("R3 strobe order errors", orderErr, 0);

    // playback: two passes to cross the wrap
    for (int p = 0; p < 2; p++) begin
      for (int i = 0; i < NLOC; i++) begin
        sinBit = ~VEC[i][4];
        pulseTick();
        waitCyc(STEP_WAIT);
        check("R7 read row", int'(lastRow), int'(VEC[i][1:0]));
        check("R7 read col", int'(lastCol), int'(VEC[i][3:2]));
        check("R7 played bit", int'(sOut), int'(VEC[i][4]));
        check("R8 no write in play", int'(lastWasWrite), 0);
      end
    end
    check("R8 data drive in play", doeInPlay, 0);
    check("R6 mode sticky", int'(playMode), 1);

    // R9: no tick, no access
    acc0 = accesses;
    waitCyc(150);
    check("R9 idle accesses", accesses - acc0, 0);

    // R10: tick during a busy step is kept
    acc0 = accesses;
    pulseTick();
    waitCyc(4);
    pulseTick();
    waitCyc(2 * STEP_WAIT);
    check("R10 pending tick steps", accesses - acc0, 2);
    check("R10 second read row", int'(lastRow), 1);

    // R1: reset in the middle of a refresh burst
    pulseTick();
    waitCyc(5);
    rstN = 1'b0;
    waitCyc(1);
    check("R1 rasN mid reset", int'(dramRasN), 1);
    check("R1 casN mid reset", int'(dramCasN), 1);
    check("R1 ctlOe mid reset", int'(ctlOe), 0);
    check("R1 mode cleared", int'(playMode), 0);
    rstN = 1'b1;
    waitCyc(2);
    sinBit = 1'b1;
    pulseTick();
    waitCyc(STEP_WAIT);
    check("R2 restart row", int'(lastRow), 0);
    check("R2 restart col", int'(lastCol), 0);
    check("R5 refresh after reset", lastRef, NREF);
    check("R4 restart write", int'(lastWasWrite), 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule